// File: doc/BRIEF.md
# Pipelined Bus Request Issuer

This block sits on the master side of a shared address/data bus. It drains a local request queue and places each entry on the bus as a single queued request, without waiting for any per-request acknowledgement. Each queue entry holds a 4-bit command, a 64-bit byte address and a 3-bit length code. When the queue holds work and the outstanding-request budget allows it, the block pulls its bus request low. It then waits until the arbiter grants the bus with the status code for "master may queue requests". From the next cycle on it drives one request per cycle, with the pipelining strobe held low.

A burst of requests ends in one of two cases: the queue has no further entry, or the outstanding count reaches the programmed ceiling. The cycle that carries the final request has the bus request already released. In the cycle after it, the strobe goes high and the output enables are withdrawn. A request whose address is at or above 4 GiB is sent in two cycles. The first cycle carries an escape command with the low address word. The second cycle carries the high address word with the true command. Such a pair counts as one outstanding request. Fence requests never use budget. Every other request adds one to the outstanding count, and each completion pulse takes one away.

Top module: `pipe_req_issuer`

## Requirements
- R1: After reset, `req_n` and `pipe_n` are high, `bus_oe` is low and `outstanding` is zero.
- R2: No request cycle (`pipe_n` low) begins until the block has sampled `gnt_n` low together with `st` equal to 3'b111 at a clock edge. With `gnt_n` high or any other `st` value, the block keeps `req_n` low and `pipe_n` high.
- R3: During a request cycle for an address below 2^32, `cbe_o` carries the command, `ad_o[31:3]` carries address bits 31:3 and `ad_o[2:0]` carries the length code. `bus_oe` is high exactly in the cycles where `pipe_n` is low.
- R4: The requests of one burst occupy consecutive clock cycles with no gaps. The queue is popped exactly once per request.
- R5: `req_n` is high during the cycle that carries the last request of a burst. In the cycle after it, `pipe_n` is high and `bus_oe` is low.
- R6: A request with a nonzero address[63:32] takes two consecutive cycles. The first has `cbe_o` = 4'b1101 and `ad_o` = {address[31:3], length}. The second has `cbe_o` = the command and `ad_o` = address[63:32]. The pair raises `outstanding` by one.
- R7: Each non-fence request raises `outstanding` by one. A burst ends at the request that brings `outstanding` up to `max_out`. No new non-fence burst starts while `outstanding` >= `max_out`.
- R8: A fence (command 4'b1100) leaves `outstanding` unchanged. A fence may be issued even when `outstanding` equals `max_out`.
- R9: A one-cycle `cpl` pulse lowers `outstanding` by one. When neither `cpl` nor a pop occurs, `outstanding` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_empty | input | 1 | Local queue holds no entry |
| src_more | input | 1 | Local queue holds at least two entries |
| src_cmd | input | 4 | Command of the queue head |
| src_addr | input | 64 | Byte address of the queue head |
| src_len | input | 3 | Length code of the queue head |
| src_pop | output | 1 | Head consumed at this clock edge |
| max_out | input | CNT_W | Ceiling on outstanding requests |
| cpl | input | 1 | One request completed |
| gnt_n | input | 1 | Bus grant, active low |
| st | input | 3 | Grant status code |
| req_n | output | 1 | Bus request, active low |
| pipe_n | output | 1 | Pipelined request strobe, active low |
| bus_oe | output | 1 | Output enable for cbe_o and ad_o |
| cbe_o | output | 4 | Command lines |
| ad_o | output | 32 | Address/length lines |
| outstanding | output | CNT_W | Current outstanding request count |

## Verification
The issuer is driven with several input patterns:
- A lone request held back first by a missing grant and then by a wrong status code. This separates waiting on the grant from waiting on the status.
- A three-entry burst with mixed commands and lengths. This exposes field placement, gaps between requests and early release of the bus request.
- A high address followed by a low one. This shows whether the escape cycle and the high word are ordered correctly, and that the pair is counted once.
- A ceiling of two against four queued reads, and a ceiling of one with a fence in the queue. These separate a burst cut short by budget from one cut short by an empty queue, and show whether fences are charged against the budget.

// File: rtl/pri_pkg.sv
// Package: shared request type, command codes and issuer states.
// Assumes: command encodings are fixed by the bus protocol.
package pri_pkg;
    typedef logic [3:0] cmd_t;

    localparam cmd_t CMD_FENCE = 4'b1100;
    localparam cmd_t CMD_DAC   = 4'b1101;
    localparam logic [2:0] ST_QUEUE = 3'b111;

    typedef struct packed {
        cmd_t        cmd;
        logic [63:0] addr;
        logic [2:0]  len;
    } preq_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ARB   = 2'd1,
        S_BURST = 2'd2
    } iss_state_t;
endpackage

// File: rtl/pri_credit_ctr.sv
// Module: outstanding-request counter.
// Counts issued requests up and completions down. A completion that
// arrives while the count is zero, with no issue in the same cycle,
// is dropped. Assumes the caller never issues past the ceiling.
module pri_credit_ctr #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic dec_ok;

    // Next count: apply an issue and a completion together.
    always_comb begin
        dec_ok  = dec && ((cnt != '0) || inc);
        cnt_nxt = cnt + CNT_W'(inc) - CNT_W'(dec_ok);
    end

    // Hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end
endmodule

// File: rtl/pri_req_fmt.sv
// Module: request cycle formatter (combinational).
// Maps one request and the cycle index within it to command-line and
// address-line values. A high address gets an escape cycle first.
// Assumes hi_phase is set only for the second cycle of a high address.
module pri_req_fmt
    import pri_pkg::*;
(
    input  preq_t       req,
    input  logic        hi_phase,
    output cmd_t        cbe,
    output logic [31:0] ad
);
    logic is_high;

    // Pick the command and address word for this cycle.
    always_comb begin
        is_high = |req.addr[63:32];
        if (hi_phase) begin
            cbe = req.cmd;
            ad  = req.addr[63:32];
        end else begin
            cbe = is_high ? CMD_DAC : req.cmd;
            ad  = {req.addr[31:3], req.len};
        end
    end
endmodule

// File: rtl/pipe_req_issuer.sv
// Module: pipelined request issuer (top).
// Drains a show-ahead queue and issues one request per cycle under an
// outstanding-count ceiling. Registered active-low strobes.
// Assumes: the grant is held for the whole burst once given; queue
// entries are not withdrawn; max_out changes only in reset.
module pipe_req_issuer
    import pri_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_empty,
    input  logic             src_more,
    input  logic [3:0]       src_cmd,
    input  logic [63:0]      src_addr,
    input  logic [2:0]       src_len,
    output logic             src_pop,
    input  logic [CNT_W-1:0] max_out,
    input  logic             cpl,
    input  logic             gnt_n,
    input  logic [2:0]       st,
    output logic             req_n,
    output logic             pipe_n,
    output logic             bus_oe,
    output logic [3:0]       cbe_o,
    output logic [31:0]      ad_o,
    output logic [CNT_W-1:0] outstanding
);
    iss_state_t       state;
    preq_t            head, held, fmt_in;
    logic             in_dac1, held_last;
    logic             head_fence, head_high, grant_ok;
    logic             load_first, load_second, burst_end, last_if_load;
    logic [CNT_W-1:0] cnt_nxt;
    cmd_t             f_cbe;
    logic [31:0]      f_ad;

    // Decode the head entry and the next-cycle actions.
    always_comb begin
        head         = '{cmd: src_cmd, addr: src_addr, len: src_len};
        head_fence   = (src_cmd == CMD_FENCE);
        head_high    = |src_addr[63:32];
        grant_ok     = !gnt_n && (st == ST_QUEUE);
        load_first   = ((state == S_ARB) && grant_ok) ||
                       ((state == S_BURST) && !in_dac1 && !held_last);
        load_second  = (state == S_BURST) && in_dac1;
        burst_end    = (state == S_BURST) && !in_dac1 && held_last;
        last_if_load = !src_more || (cnt_nxt >= max_out);
        fmt_in       = load_second ? held : head;
    end

    assign src_pop = load_first;

    pri_credit_ctr #(.CNT_W(CNT_W)) credit_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (load_first && !head_fence),
        .dec     (cpl),
        .cnt     (outstanding),
        .cnt_nxt (cnt_nxt)
    );

    pri_req_fmt fmt_i (
        .req      (fmt_in),
        .hi_phase (load_second),
        .cbe      (f_cbe),
        .ad       (f_ad)
    );

    // Sequence arbitration, burst issue and termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            req_n     <= 1'b1;
            pipe_n    <= 1'b1;
            bus_oe    <= 1'b0;
            cbe_o     <= '0;
            ad_o      <= '0;
            in_dac1   <= 1'b0;
            held_last <= 1'b0;
            held      <= '0;
        end else if (load_first) begin
            held      <= head;
            pipe_n    <= 1'b0;
            bus_oe    <= 1'b1;
            cbe_o     <= f_cbe;
            ad_o      <= f_ad;
            in_dac1   <= head_high;
            held_last <= last_if_load;
            req_n     <= head_high ? 1'b0 : last_if_load;
            state     <= S_BURST;
        end else if (load_second) begin
            cbe_o   <= f_cbe;
            ad_o    <= f_ad;
            in_dac1 <= 1'b0;
            req_n   <= held_last;
        end else if (burst_end) begin
            pipe_n    <= 1'b1;
            bus_oe    <= 1'b0;
            cbe_o     <= '0;
            ad_o      <= '0;
            req_n     <= 1'b1;
            held_last <= 1'b0;
            state     <= S_IDLE;
        end else if ((state == S_IDLE) && !src_empty &&
                     ((outstanding < max_out) || head_fence)) begin
            req_n <= 1'b0;
            state <= S_ARB;
        end
    end
endmodule

// File: rtl/pri_issuer_chk.sv
// Module: protocol checker for the issuer, bound to the top.
// Assumes max_out is stable outside reset.
module pri_issuer_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_pop,
    input logic [CNT_W-1:0] max_out,
    input logic             cpl,
    input logic             gnt_n,
    input logic [2:0]       st,
    input logic             req_n,
    input logic             pipe_n,
    input logic             bus_oe,
    input logic [3:0]       cbe_o,
    input logic [CNT_W-1:0] outstanding
);
    // R2: a burst starts only after a queue-status grant.
    a_r2_start_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pipe_n) |-> $past(!gnt_n && (st == 3'b111)));

    // R3: drivers are enabled exactly while the strobe is low.
    a_r3_oe_tracks_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe == !pipe_n);

    // R5: the strobe rises only after a cycle with the request released.
    a_r5_pipe_rise_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pipe_n) |-> $past(req_n));

    // R5: a request cycle with req_n high is followed by an idle cycle.
    a_r5_last_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_n && req_n) |=> pipe_n);

    // R6: an escape cycle is followed by its second cycle.
    a_r6_dac_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_n && (cbe_o == 4'b1101)) |=> (!pipe_n && (cbe_o != 4'b1101)));

    // R7: the count never exceeds the ceiling while issuing.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_n |-> (outstanding <= max_out));

    // R9: the count holds with no completion and no pop.
    a_r9_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpl && !src_pop) |=> $stable(outstanding));
endmodule

bind pipe_req_issuer pri_issuer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_pop     (src_pop),
    .max_out     (max_out),
    .cpl         (cpl),
    .gnt_n       (gnt_n),
    .st          (st),
    .req_n       (req_n),
    .pipe_n      (pipe_n),
    .bus_oe      (bus_oe),
    .cbe_o       (cbe_o),
    .outstanding (outstanding)
);

// File: tb/pipe_req_issuer_tb_top.sv
// Bench: directed scenarios for the pipelined request issuer.
// Models the local queue, records every request cycle, checks results.
module pipe_req_issuer_tb_top;
    localparam int CNT_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] max_out = 5'd8;
    logic             cpl = 1'b0;
    logic             gnt_n = 1'b0;
    logic [2:0]       st = 3'b111;
    logic             src_pop, req_n, pipe_n, bus_oe;
    logic [3:0]       cbe_o;
    logic [31:0]      ad_o;
    logic [CNT_W-1:0] outstanding;

    // Queue model
    logic [3:0]  q_cmd  [0:15];
    logic [63:0] q_addr [0:15];
    logic [2:0]  q_len  [0:15];
    int          wr = 0;
    int          rd = 0;
    logic        src_empty, src_more;
    logic [3:0]  src_cmd;
    logic [63:0] src_addr;
    logic [2:0]  src_len;

    assign src_empty = (rd >= wr);
    assign src_more  = (wr - rd) >= 2;
    assign src_cmd   = q_cmd[rd[3:0]];
    assign src_addr  = q_addr[rd[3:0]];
    assign src_len   = q_len[rd[3:0]];

    // Request-cycle log
    logic [3:0]  lg_cbe [0:15];
    logic [31:0] lg_ad  [0:15];
    logic        lg_req [0:15];
    int          lg_cyc [0:15];
    int          lg_n = 0;
    int          cyc = 0;

    int checks = 0;
    int errors = 0;

    pipe_req_issuer #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_empty(src_empty), .src_more(src_more),
        .src_cmd(src_cmd), .src_addr(src_addr), .src_len(src_len),
        .src_pop(src_pop), .max_out(max_out), .cpl(cpl),
        .gnt_n(gnt_n), .st(st), .req_n(req_n), .pipe_n(pipe_n),
        .bus_oe(bus_oe), .cbe_o(cbe_o), .ad_o(ad_o),
        .outstanding(outstanding)
    );

    always #5 clk = ~clk;

    // Advance the queue read pointer on each pop.
    always @(posedge clk) begin
        if (!rst_n)       rd <= 0;
        else if (src_pop) rd <= rd + 1;
    end

    // Record every request cycle away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) lg_n = 0;
        else if (!pipe_n && lg_n < 16) begin
            lg_cbe[lg_n] = cbe_o;
            lg_ad[lg_n]  = ad_o;
            lg_req[lg_n] = req_n;
            lg_cyc[lg_n] = cyc;
            lg_n = lg_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] c, input logic [63:0] a, input logic [2:0] l);
        q_cmd[wr[3:0]]  = c;
        q_addr[wr[3:0]] = a;
        q_len[wr[3:0]]  = l;
        wr = wr + 1;
    endtask

    task automatic restart(input logic [CNT_W-1:0] mx);
        @(negedge clk);
        rst_n = 1'b0;
        wr = 0;
        max_out = mx;
        cpl = 1'b0;
        gnt_n = 1'b0;
        st = 3'b111;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_cpl();
        cpl = 1'b1;
        @(negedge clk);
        cpl = 1'b0;
    endtask

    function automatic logic [31:0] lo_word(input logic [63:0] a, input logic [2:0] l);
        return {a[31:3], l};
    endfunction

    // R1: reset values.
    task automatic t_reset();
        restart(5'd8);
        chk(req_n == 1'b1, "R1 req_n", req_n, 1);
        chk(pipe_n == 1'b1 && bus_oe == 1'b0, "R1 pipe_n/bus_oe", {pipe_n, bus_oe}, 2'b10);
        chk(outstanding == 0, "R1 outstanding", outstanding, 0);
        rst_n = 1'b1;
    endtask

    // R2: waits for grant plus queue status.
    task automatic t_grant();
        restart(5'd8);
        gnt_n = 1'b1;
        push(4'b0000, 64'h40, 3'd1);
        rst_n = 1'b1;
        run_cycles(5);
        chk(req_n == 1'b0 && pipe_n == 1'b1, "R2 no grant", {req_n, pipe_n}, 2'b01);
        gnt_n = 1'b0;
        st = 3'b010;
        run_cycles(5);
        chk(pipe_n == 1'b1 && lg_n == 0, "R2 wrong status", lg_n, 0);
        st = 3'b111;
        run_cycles(1);
        chk(pipe_n == 1'b0, "R2 starts after status 111", pipe_n, 0);
        run_cycles(4);
        chk(lg_n == 1, "R2 one request", lg_n, 1);
    endtask

    // R3, R4, R5: three-request burst.
    task automatic t_burst();
        logic [63:0] a [0:2];
        logic [3:0]  c [0:2];
        logic [2:0]  l [0:2];
        a[0] = 64'h1000;      c[0] = 4'b0000; l[0] = 3'd7;
        a[1] = 64'h2008;      c[1] = 4'b0100; l[1] = 3'd0;
        a[2] = 64'hFFFF_FFF8; c[2] = 4'b0001; l[2] = 3'd3;
        restart(5'd8);
        for (int i = 0; i < 3; i++) push(c[i], a[i], l[i]);
        rst_n = 1'b1;
        run_cycles(12);
        chk(lg_n == 3, "R4 request count", lg_n, 3);
        chk(rd == 3, "R4 pops", rd, 3);
        for (int i = 0; i < 3; i++) begin
            chk(lg_cbe[i] == c[i], "R3 command lines", lg_cbe[i], c[i]);
            chk(lg_ad[i] == lo_word(a[i], l[i]), "R3 address/length", lg_ad[i], lo_word(a[i], l[i]));
        end
        chk(lg_cyc[1] == lg_cyc[0] + 1 && lg_cyc[2] == lg_cyc[1] + 1,
            "R4 consecutive", lg_cyc[2] - lg_cyc[0], 2);
        chk({lg_req[0], lg_req[1], lg_req[2]} == 3'b001, "R5 req_n pattern",
            {lg_req[0], lg_req[1], lg_req[2]}, 3'b001);
        chk(pipe_n == 1'b1 && bus_oe == 1'b0, "R5 idle after last", {pipe_n, bus_oe}, 2'b10);
        chk(outstanding == 3, "R7 count after burst", outstanding, 3);
    endtask

    // R6: high address uses an escape cycle, counted once.
    task automatic t_dac();
        logic [63:0] ha;
        ha = 64'h0000_0001_2345_6780;
        restart(5'd8);
        push(4'b0000, ha, 3'd2);
        push(4'b0100, 64'hABCD_0010, 3'd0);
        rst_n = 1'b1;
        run_cycles(12);
        chk(lg_n == 3, "R6 cycle count", lg_n, 3);
        chk(lg_cbe[0] == 4'b1101, "R6 escape command", lg_cbe[0], 4'b1101);
        chk(lg_ad[0] == lo_word(ha, 3'd2), "R6 low word", lg_ad[0], lo_word(ha, 3'd2));
        chk(lg_cbe[1] == 4'b0000, "R6 real command", lg_cbe[1], 0);
        chk(lg_ad[1] == 32'h1, "R6 high word", lg_ad[1], 1);
        chk(lg_cyc[1] == lg_cyc[0] + 1, "R6 consecutive", lg_cyc[1] - lg_cyc[0], 1);
        chk({lg_req[0], lg_req[1], lg_req[2]} == 3'b001, "R6 req_n pattern",
            {lg_req[0], lg_req[1], lg_req[2]}, 3'b001);
        chk(outstanding == 2, "R6 pair counts once", outstanding, 2);
    endtask

    // R7, R9: ceiling ends a burst and completions reopen it.
    task automatic t_credit();
        restart(5'd2);
        for (int i = 0; i < 4; i++) push(4'b0000, 64'h100 + 64'(i * 8), 3'd0);
        rst_n = 1'b1;
        run_cycles(12);
        chk(lg_n == 2, "R7 burst cut at ceiling", lg_n, 2);
        chk(lg_req[1] == 1'b1, "R7 last marked", lg_req[1], 1);
        chk(req_n == 1'b1 && outstanding == 2, "R7 no new request",
            {req_n, outstanding}, {1'b1, 5'd2});
        pulse_cpl();
        chk(outstanding == 1, "R9 completion decrements", outstanding, 1);
        run_cycles(8);
        chk(lg_n == 3 && outstanding == 2, "R7 one more after completion", lg_n, 3);
        pulse_cpl();
        pulse_cpl();
        run_cycles(8);
        chk(lg_n == 4 && outstanding == 1, "R9 final count", outstanding, 1);
    endtask

    // R8: fence passes a full budget and is not counted.
    task automatic t_fence();
        restart(5'd1);
        push(4'b0000, 64'h200, 3'd0);
        push(4'b1100, 64'h0,   3'd0);
        push(4'b0000, 64'h208, 3'd1);
        rst_n = 1'b1;
        run_cycles(14);
        chk(lg_n == 2, "R8 fence issued at ceiling", lg_n, 2);
        chk(lg_cbe[1] == 4'b1100, "R8 fence command", lg_cbe[1], 4'b1100);
        chk(outstanding == 1, "R8 fence not counted", outstanding, 1);
        pulse_cpl();
        run_cycles(8);
        chk(lg_n == 3 && outstanding == 1, "R8 read after fence", lg_n, 3);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: all requirements, actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_grant();
        t_burst();
        t_dac();
        t_credit();
        t_fence();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule